// File: doc/BRIEF.md
# Rename-Group Source Correction and Map-Write Selection

A group of up to four instructions is renamed in a single cycle. The map table is read for every source and every destination of the group at once, so a younger instruction in the group that reads a register written by an older instruction in the same group gets a stale physical register from the table. This block sits beside the table lookup and repairs those results. Each source field of a younger slot is compared with the destination fields of the older slots. When a source matches, the freshly allocated physical register of the closest older writer replaces the table value.

The same comparison produces the previous mapping that each writer records for later rollback. The block also chooses which destination mappings go into the table, so that a register written several times within a group ends up with the mapping of its youngest writer. Slot 0 is the oldest slot in the group. Per-slot valid bits let a partial group pass through. The block is purely combinational. The table itself and the free list are outside it, and the new physical registers come in as inputs.

Top module: `rn_dep_check`

## Requirements
- R1: Slot 0 is never corrected. Its source results and its previous-destination result equal the table values unchanged.
- R2: For slot i>0, a source (Rs or Rt, each handled on its own) that equals the destination of one or more qualifying older slots is replaced by the new physical register of the youngest of those older slots.
- R3: A source that matches no qualifying older slot is passed through from the table lookup.
- R4: An older slot qualifies as a writer only when both its slot-valid bit and its destination-valid bit are 1. Other slots never supply a substitute and never suppress a table write.
- R5: Architectural register 0 never matches. A source of value 0 is always passed through, and a slot whose destination is 0 never qualifies as a writer.
- R6: The table write enable of slot i is 1 exactly when slot i qualifies as a writer and no younger qualifying slot in the group has the same destination.
- R7: The previous-mapping output of slot i is the new physical register of the youngest qualifying older slot whose destination equals slot i's destination. If there is none, it is the table lookup of that destination.
- R8: Field packing on every vector port: slot i occupies bits [i*W +: W], where W is the field width. Bit i of the single-bit vectors belongs to slot i.

Ports use the default configuration: N=4 slots, A=5 architectural index bits, P=7 physical index bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slot_vld | input | N | Slot holds an instruction |
| dst_vld | input | N | Slot writes a destination register |
| rs_idx | input | N*A | First source architectural index per slot |
| rt_idx | input | N*A | Second source architectural index per slot |
| rd_idx | input | N*A | Destination architectural index per slot |
| ps_tbl | input | N*P | Table lookup of rs per slot |
| pt_tbl | input | N*P | Table lookup of rt per slot |
| pold_tbl | input | N*P | Table lookup of rd per slot |
| pd_new | input | N*P | Newly allocated physical destination per slot |
| ps_fix | output | N*P | Corrected physical register for rs |
| pt_fix | output | N*P | Corrected physical register for rt |
| pold_fix | output | N*P | Previous mapping of rd, for rollback |
| map_we | output | N | Write slot's rd to pd_new in the table |

## Verification
The bench uses a 2-bit architectural index. Dense collisions are therefore common: several older slots write the same register, slots are invalid or have no destination in the middle of a chain, and register 0 is used as both source and destination. A priority scan that picks the oldest match instead of the youngest would return the wrong physical register whenever two older slots write the same register. Ignoring either valid bit would forward from a slot that writes nothing. Letting register 0 match would corrupt reads of the zero register. For write selection, a wrong design would either write a register twice in one group, leaving the older mapping live, or drop the single write of a register. The previous-mapping path is checked the same way, so that a mistake in it would show up as a wrong rollback register.

// File: rtl/rn_dep_pkg.sv
// Package: default sizes shared by the rename dependence logic.
// Assumes slot 0 is the oldest instruction of a group.
package rn_dep_pkg;
    localparam int unsigned RN_SLOTS  = 4;
    localparam int unsigned RN_AREG_W = 5;
    localparam int unsigned RN_PREG_W = 7;
endpackage

// File: rtl/rn_dep_qual.sv
// Module: decides per slot whether it counts as an in-group writer.
// Assumes register index 0 is the hard-wired zero register.
module rn_dep_qual #(
    parameter int unsigned N = 4,
    parameter int unsigned A = 5
) (
    input  logic [N-1:0]   slot_vld,
    input  logic [N-1:0]   dst_vld,
    input  logic [N*A-1:0] rd_idx,
    output logic [N-1:0]   wr_ok
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        // Writer only if present, writing, and not the zero register.
        always_comb begin
            wr_ok[i] = slot_vld[i] && dst_vld[i] && (rd_idx[i*A +: A] != '0);
        end
    end
endmodule

// File: rtl/rn_dep_match.sv
// Module: priority lookup of one architectural index among older slots.
// Scans slots 0..POS-1 and keeps the youngest qualifying match; falls
// back to the table value. Assumes wr_ok already excludes register 0.
module rn_dep_match #(
    parameter int unsigned N   = 4,
    parameter int unsigned A   = 5,
    parameter int unsigned P   = 7,
    parameter int unsigned POS = 0
) (
    input  logic [A-1:0]   key,
    input  logic [P-1:0]   dflt,
    input  logic [N-1:0]   wr_ok,
    input  logic [N*A-1:0] rd_idx,
    input  logic [N*P-1:0] pd_new,
    output logic [P-1:0]   result
);
    // Ascending scan: a later (younger) hit overwrites an earlier one.
    always_comb begin
        result = dflt;
        for (int j = 0; j < int'(N); j++) begin
            if ((j < int'(POS)) && wr_ok[j] && (rd_idx[j*A +: A] == key)) begin
                result = pd_new[j*P +: P];
            end
        end
    end
endmodule

// File: rtl/rn_dep_commit.sv
// Module: chooses which destination mappings reach the table.
// A writer is dropped when a younger writer in the group names the
// same register. Assumes wr_ok is the qualified writer mask.
module rn_dep_commit #(
    parameter int unsigned N = 4,
    parameter int unsigned A = 5
) (
    input  logic [N-1:0]   wr_ok,
    input  logic [N*A-1:0] rd_idx,
    output logic [N-1:0]   map_we
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        // Keep slot i only if no younger writer shares its destination.
        always_comb begin
            map_we[i] = wr_ok[i];
            for (int j = i + 1; j < int'(N); j++) begin
                if (wr_ok[j] && (rd_idx[j*A +: A] == rd_idx[i*A +: A])) begin
                    map_we[i] = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/rn_dep_check.sv
// Module: in-group dependence correction for a parallel rename lookup.
// Corrects both sources and the previous destination mapping of each
// slot against older in-group writers and selects the table writes.
// Assumes slot 0 is oldest; purely combinational, no clock or reset.
module rn_dep_check
    import rn_dep_pkg::*;
#(
    parameter int unsigned N = RN_SLOTS,
    parameter int unsigned A = RN_AREG_W,
    parameter int unsigned P = RN_PREG_W
) (
    input  logic [N-1:0]   slot_vld,
    input  logic [N-1:0]   dst_vld,
    input  logic [N*A-1:0] rs_idx,
    input  logic [N*A-1:0] rt_idx,
    input  logic [N*A-1:0] rd_idx,
    input  logic [N*P-1:0] ps_tbl,
    input  logic [N*P-1:0] pt_tbl,
    input  logic [N*P-1:0] pold_tbl,
    input  logic [N*P-1:0] pd_new,
    output logic [N*P-1:0] ps_fix,
    output logic [N*P-1:0] pt_fix,
    output logic [N*P-1:0] pold_fix,
    output logic [N-1:0]   map_we
);
    logic [N-1:0] wr_ok;

    rn_dep_qual #(.N(N), .A(A)) qual_i (
        .slot_vld (slot_vld),
        .dst_vld  (dst_vld),
        .rd_idx   (rd_idx),
        .wr_ok    (wr_ok)
    );

    for (genvar i = 0; i < N; i++) begin : g_slot
        rn_dep_match #(.N(N), .A(A), .P(P), .POS(i)) rs_m (
            .key    (rs_idx[i*A +: A]),
            .dflt   (ps_tbl[i*P +: P]),
            .wr_ok  (wr_ok),
            .rd_idx (rd_idx),
            .pd_new (pd_new),
            .result (ps_fix[i*P +: P])
        );
        rn_dep_match #(.N(N), .A(A), .P(P), .POS(i)) rt_m (
            .key    (rt_idx[i*A +: A]),
            .dflt   (pt_tbl[i*P +: P]),
            .wr_ok  (wr_ok),
            .rd_idx (rd_idx),
            .pd_new (pd_new),
            .result (pt_fix[i*P +: P])
        );
        rn_dep_match #(.N(N), .A(A), .P(P), .POS(i)) old_m (
            .key    (rd_idx[i*A +: A]),
            .dflt   (pold_tbl[i*P +: P]),
            .wr_ok  (wr_ok),
            .rd_idx (rd_idx),
            .pd_new (pd_new),
            .result (pold_fix[i*P +: P])
        );
    end

    rn_dep_commit #(.N(N), .A(A)) commit_i (
        .wr_ok  (wr_ok),
        .rd_idx (rd_idx),
        .map_we (map_we)
    );
endmodule

// File: rtl/rn_dep_check_sva.sv
// Module: checker for rn_dep_check, bound to every instance.
// Uses immediate assertions since the block has no clock.
module rn_dep_check_sva #(
    parameter int unsigned N = 4,
    parameter int unsigned A = 5,
    parameter int unsigned P = 7
) (
    input logic [N-1:0]   slot_vld,
    input logic [N-1:0]   dst_vld,
    input logic [N*A-1:0] rs_idx,
    input logic [N*A-1:0] rd_idx,
    input logic [N*P-1:0] ps_tbl,
    input logic [N*P-1:0] pt_tbl,
    input logic [N*P-1:0] pold_tbl,
    input logic [N*P-1:0] pd_new,
    input logic [N*P-1:0] ps_fix,
    input logic [N*P-1:0] pt_fix,
    input logic [N*P-1:0] pold_fix,
    input logic [N-1:0]   map_we
);
    // Relate outputs to inputs whenever anything changes.
    always_comb begin
        // R1
        slot0_pass_chk: assert (ps_fix[0 +: P] == ps_tbl[0 +: P] &&
                                pt_fix[0 +: P] == pt_tbl[0 +: P] &&
                                pold_fix[0 +: P] == pold_tbl[0 +: P]);
        for (int i = 0; i < int'(N); i++) begin
            // R5
            zero_src_chk: assert (rs_idx[i*A +: A] != '0 ||
                                  ps_fix[i*P +: P] == ps_tbl[i*P +: P]);
            // R4
            we_qual_chk: assert (!map_we[i] ||
                                 (slot_vld[i] && dst_vld[i] && rd_idx[i*A +: A] != '0));
            for (int j = i + 1; j < int'(N); j++) begin
                // R6
                we_unique_chk: assert (!(map_we[i] && map_we[j]) ||
                                       rd_idx[i*A +: A] != rd_idx[j*A +: A]);
            end
            if (i > 0) begin
                if (slot_vld[i-1] && dst_vld[i-1] && rd_idx[(i-1)*A +: A] != '0) begin
                    // R2
                    near_src_chk: assert (rs_idx[i*A +: A] != rd_idx[(i-1)*A +: A] ||
                                          ps_fix[i*P +: P] == pd_new[(i-1)*P +: P]);
                    // R7
                    near_old_chk: assert (rd_idx[i*A +: A] != rd_idx[(i-1)*A +: A] ||
                                          pold_fix[i*P +: P] == pd_new[(i-1)*P +: P]);
                end
            end
        end
    end
endmodule

bind rn_dep_check rn_dep_check_sva #(.N(N), .A(A), .P(P)) sva_i (
    .slot_vld (slot_vld),
    .dst_vld  (dst_vld),
    .rs_idx   (rs_idx),
    .rd_idx   (rd_idx),
    .ps_tbl   (ps_tbl),
    .pt_tbl   (pt_tbl),
    .pold_tbl (pold_tbl),
    .pd_new   (pd_new),
    .ps_fix   (ps_fix),
    .pt_fix   (pt_fix),
    .pold_fix (pold_fix),
    .map_we   (map_we)
);

// File: tb/rn_dep_check_tb.sv
// Bench: dense random and directed sweeps on a 2-bit register space.
module rn_dep_check_tb_top;
    localparam int N = 4;
    localparam int A = 2;
    localparam int P = 7;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    logic [N-1:0]   slot_vld, dst_vld, map_we;
    logic [N*A-1:0] rs_idx, rt_idx, rd_idx;
    logic [N*P-1:0] ps_tbl, pt_tbl, pold_tbl, pd_new, ps_fix, pt_fix, pold_fix;

    always #(CLK_PERIOD/2) clk = ~clk;

    rn_dep_check #(.N(N), .A(A), .P(P)) dut_i (
        .slot_vld (slot_vld), .dst_vld (dst_vld),
        .rs_idx (rs_idx), .rt_idx (rt_idx), .rd_idx (rd_idx),
        .ps_tbl (ps_tbl), .pt_tbl (pt_tbl), .pold_tbl (pold_tbl),
        .pd_new (pd_new), .ps_fix (ps_fix), .pt_fix (pt_fix),
        .pold_fix (pold_fix), .map_we (map_we)
    );

    function automatic bit writer(int s);
        return slot_vld[s] && dst_vld[s] && (rd_idx[s*A +: A] != 0);
    endfunction

    // Youngest qualifying older writer of key; -1 if none.
    function automatic int src_of(int pos, logic [A-1:0] key);
        int w = -1;
        for (int j = 0; j < pos; j++)
            if (writer(j) && rd_idx[j*A +: A] == key) w = j;
        return w;
    endfunction

    task automatic chk(string req, int slot, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s slot %0d: actual %0d expected %0d", req, slot, act, exp);
        end
    endtask

    // Compare all outputs against the requirement model; tag with req.
    task automatic check_all(string tag);
        for (int i = 0; i < N; i++) begin
            int ws = src_of(i, rs_idx[i*A +: A]);
            int wt = src_of(i, rt_idx[i*A +: A]);
            int wo = src_of(i, rd_idx[i*A +: A]);
            int es = (ws < 0) ? int'(ps_tbl[i*P +: P]) : int'(pd_new[ws*P +: P]);
            int et = (wt < 0) ? int'(pt_tbl[i*P +: P]) : int'(pd_new[wt*P +: P]);
            int eo = (wo < 0) ? int'(pold_tbl[i*P +: P]) : int'(pd_new[wo*P +: P]);
            bit ew = writer(i);
            for (int j = i + 1; j < N; j++)
                if (writer(j) && rd_idx[j*A +: A] == rd_idx[i*A +: A]) ew = 1'b0;
            if (tag != "") begin
                chk(tag, i, int'(ps_fix[i*P +: P]), es);
                chk(tag, i, int'(pt_fix[i*P +: P]), et);
                chk(tag, i, int'(pold_fix[i*P +: P]), eo);
                chk(tag, i, int'(map_we[i]), int'(ew));
            end else begin
                chk((i == 0) ? "R1" : ((ws < 0) ? "R3" : "R2"), i, int'(ps_fix[i*P +: P]), es);
                chk((i == 0) ? "R1" : ((wt < 0) ? "R3" : "R2"), i, int'(pt_fix[i*P +: P]), et);
                chk("R7", i, int'(pold_fix[i*P +: P]), eo);
                chk("R6", i, int'(map_we[i]), int'(ew));
            end
        end
    endtask

    task automatic rand_vec();
        slot_vld = N'($urandom); dst_vld = N'($urandom);
        rs_idx = (N*A)'($urandom); rt_idx = (N*A)'($urandom); rd_idx = (N*A)'($urandom);
        for (int i = 0; i < N; i++) begin
            ps_tbl[i*P +: P]   = P'(10 + i);
            pt_tbl[i*P +: P]   = P'(20 + i);
            pold_tbl[i*P +: P] = P'(30 + i);
            pd_new[i*P +: P]   = P'(64 + i * 8 + ($urandom % 8));
        end
    endtask

    initial begin
        rand_vec();
        slot_vld = '0; dst_vld = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Empty group: nothing written, everything passes through (R4, R8).
        @(negedge clk); check_all("R4");
        // Every slot writes register 1 and reads it (R2, R6, R8).
        @(posedge clk); #1;
        slot_vld = '1; dst_vld = '1;
        for (int i = 0; i < N; i++) begin
            rs_idx[i*A +: A] = 2'd1; rt_idx[i*A +: A] = 2'd1; rd_idx[i*A +: A] = 2'd1;
        end
        @(negedge clk); check_all("R2");
        chk("R6", 3, int'(map_we), 8);
        chk("R2", 3, int'(ps_fix[3*P +: P]), int'(pd_new[2*P +: P]));
        // Register 0 destinations and sources (R5).
        @(posedge clk); #1;
        rd_idx = '0; rs_idx = '0; rt_idx = '0;
        @(negedge clk); check_all("R5");
        chk("R5", 0, int'(map_we), 0);
        // Middle writer invalid: slot 2 must see slot 0 (R4).
        @(posedge clk); #1;
        for (int i = 0; i < N; i++) begin
            rs_idx[i*A +: A] = 2'd2; rt_idx[i*A +: A] = 2'd3; rd_idx[i*A +: A] = 2'd2;
        end
        slot_vld = 4'b1101; dst_vld = 4'b1111;
        @(negedge clk); check_all("R4");
        chk("R4", 2, int'(ps_fix[2*P +: P]), int'(pd_new[0*P +: P]));
        @(posedge clk); #1;
        slot_vld = 4'b1111; dst_vld = 4'b1101;
        @(negedge clk); check_all("R4");
        chk("R4", 2, int'(ps_fix[2*P +: P]), int'(pd_new[0*P +: P]));
        for (int v = 0; v < NVEC; v++) begin
            @(posedge clk); #1;
            rand_vec();
            @(negedge clk); check_all("");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule